// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor. The distributor offers the best pending interrupt for this processor: its ID, the number of the CPU that requested it (for software-generated interrupts) and its 8-bit priority. The interface compares that priority with a programmable priority mask and with the priority of the interrupt now being serviced. From this comparison it drives the processor's IRQ line.

Software claims an interrupt by reading the acknowledge register. The read has a side effect: it returns the claimed ID together with the source CPU, pushes the interrupt onto a nesting stack of active interrupts, and pulses a claim strobe back to the distributor so that the distributor can clear an edge-type pending bit. Software retires the interrupt by writing the same word to the end-of-interrupt register. The running priority then falls back to that of the interrupt below it on the stack, or to idle (0xFF).

Only the upper `PRIO_BITS` bits of any priority byte take part in comparisons. The binary point is fixed.

The nesting tracker is a state machine with three states:
- `ST_IDLE`: no interrupt is active.
- `ST_SERVING`: one or more interrupts are active and the stack has room.
- `ST_SATURATED`: the stack is full, so no further claim is possible.

The transitions are:
- *claim*: IDLE→SERVING, SERVING→SERVING, or SERVING→SATURATED when the last slot fills.
- *retire*: SATURATED→SERVING, SERVING→SERVING, or SERVING→IDLE when the last entry leaves.

With a depth of one, IDLE and SATURATED swap directly.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, the control register reads 0, the priority mask reads 0x00, the running priority reads 0xFF, the IRQ output is low and an acknowledge read returns 1023.
- R2: Bit 0 of the control register (offset 0x00) gates signalling. While it is 0, the IRQ output stays low and acknowledge reads return 1023.
- R3: The priority mask (offset 0x04) keeps only bits 7:4 of a write; bits 3:0 read as zero. An interrupt qualifies only if bits 7:4 of its priority are numerically lower than bits 7:4 of the mask.
- R4: An acknowledge read (offset 0x0C) of a qualifying interrupt returns the ID in bits 9:0 and the source CPU in bits 12:10, with all other bits zero. In that same cycle it pulses `ack_vld_o` with the ID on `ack_id_o`, and it makes the interrupt active.
- R5: When nothing qualifies, an acknowledge read returns 1023, pulses no claim strobe and changes no state.
- R6: The running priority (offset 0x14) reads bits 7:4 of the most recently claimed active interrupt's priority with bits 3:0 zero. An interrupt qualifies only if its priority bits 7:4 are strictly lower than the running priority's bits 7:4.
- R7: A write to offset 0x10 whose bits 12:0 equal the acknowledge word of the most recently claimed active interrupt retires it. The write pulses `eoi_vld_o` with the ID on `eoi_id_o`, and the running priority returns to that of the previous active entry, or to 0xFF when none remain.
- R8: An end-of-interrupt write that does not match the most recently claimed active interrupt is ignored: no strobe and no change of running priority.
- R9: Reading the highest pending register (offset 0x18) returns the offered source CPU and ID in the acknowledge format, or 1023 when nothing is offered. This read, and a running priority read, have no side effect.
- R10: The IRQ output is low in any cycle in which an acknowledge read is presented. While `NEST` interrupts are active, no interrupt qualifies and acknowledge reads return 1023.
- R11: The binary point register (offset 0x08) reads the constant 3 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_valid_i | input | 1 | Distributor offers a pending interrupt |
| pend_id_i | input | ID_W | Offered interrupt ID |
| pend_cpu_i | input | CPU_W | Requesting CPU of the offered interrupt |
| pend_prio_i | input | PRIO_W | Priority of the offered interrupt (lower is more urgent) |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | IRQ request to the processor |
| ack_vld_o | output | 1 | Claim strobe to the distributor |
| ack_id_o | output | ID_W | ID being claimed |
| eoi_vld_o | output | 1 | Retire strobe to the distributor |
| eoi_id_o | output | ID_W | ID being retired |

## Verification
The bench builds the interface with a nesting depth of three and the default field widths: 10-bit IDs, 3-bit CPU numbers, and 8-bit priorities with 4 implemented bits. The shallow stack lets directed sequences and random traffic reach the saturated state within a few claims. Once there, they can exercise refused claims, mismatched retires deep in the stack, and the walk of the running priority back down to idle. The full-width ID range and the nibble-equal priority corners stay reachable.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SERVING,
        ST_SATURATED
    } nest_state_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_PMASK  = 8'h04;
    localparam logic [7:0] OFS_BPT    = 8'h08;
    localparam logic [7:0] OFS_ACK    = 8'h0C;
    localparam logic [7:0] OFS_EOI    = 8'h10;
    localparam logic [7:0] OFS_RUN    = 8'h14;
    localparam logic [7:0] OFS_HIPEND = 8'h18;

    localparam int BPT_FIXED = 3;

endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs
    import cpuif_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PRIO_W    = 8,
    parameter int PRIO_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] ack_word,
    input  logic [DATA_W-1:0] hipend_word,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              sig_en,
    output logic [PRIO_W-1:0] pmask,
    output logic              ack_rd,
    output logic              eoi_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int LOW_W = PRIO_W - PRIO_BITS;

    logic                 en_q;
    logic [PRIO_BITS-1:0] mask_hi_q;
    logic                 rd_strobe;
    logic                 wr_strobe;

    assign rd_strobe = bus_sel && !bus_wr;
    assign wr_strobe = bus_sel && bus_wr;
    assign ack_rd    = rd_strobe && (bus_addr == ADDR_W'(OFS_ACK));
    assign eoi_wr    = wr_strobe && (bus_addr == ADDR_W'(OFS_EOI));
    assign sig_en    = en_q;

    generate
        if (LOW_W > 0) begin : g_mask_pad
            assign pmask = {mask_hi_q, {LOW_W{1'b0}}};
        end else begin : g_mask_full
            assign pmask = mask_hi_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mask_hi_q <= '0;
        end else if (wr_strobe) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                en_q <= bus_wdata[0];
            end
            if (bus_addr == ADDR_W'(OFS_PMASK)) begin
                mask_hi_q <= bus_wdata[PRIO_W-1:LOW_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_strobe) begin
            unique case (bus_addr)
                ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'(en_q);
                ADDR_W'(OFS_PMASK):  bus_rdata = DATA_W'(pmask);
                ADDR_W'(OFS_BPT):    bus_rdata = DATA_W'(BPT_FIXED);
                ADDR_W'(OFS_ACK):    bus_rdata = ack_word;
                ADDR_W'(OFS_RUN):    bus_rdata = DATA_W'(run_prio);
                ADDR_W'(OFS_HIPEND): bus_rdata = hipend_word;
                default:             bus_rdata = '0;
            endcase
        end
    end

    assert_mask_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && bus_addr == ADDR_W'(OFS_PMASK)) |=>
            (pmask[PRIO_W-1:LOW_W] == $past(bus_wdata[PRIO_W-1:LOW_W])));

    assert_bpt_const_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && bus_addr == ADDR_W'(OFS_BPT)) |-> (bus_rdata == DATA_W'(BPT_FIXED)));

endmodule

// File: rtl/cpuif_select.sv
module cpuif_select #(
    parameter int PRIO_W    = 8,
    parameter int PRIO_BITS = 4
) (
    input  logic              sig_en,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              nest_full,
    input  logic              ack_rd,
    output logic              qualify,
    output logic              irq_line
);

    logic [PRIO_BITS-1:0] pend_hi;
    logic [PRIO_BITS-1:0] mask_hi;
    logic [PRIO_BITS-1:0] run_hi;
    logic                 beats_mask;
    logic                 beats_run;

    always_comb begin
        pend_hi    = pend_prio[PRIO_W-1 -: PRIO_BITS];
        mask_hi    = pmask[PRIO_W-1 -: PRIO_BITS];
        run_hi     = run_prio[PRIO_W-1 -: PRIO_BITS];
        beats_mask = pend_hi < mask_hi;
        beats_run  = pend_hi < run_hi;
        qualify    = sig_en && pend_valid && !nest_full && beats_mask && beats_run;
        irq_line   = qualify && !ack_rd;
    end

endmodule

// File: rtl/cpuif_nest.sv
module cpuif_nest
    import cpuif_pkg::*;
#(
    parameter int NEST      = 4,
    parameter int ID_W      = 10,
    parameter int CPU_W     = 3,
    parameter int PRIO_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [CPU_W-1:0]  push_cpu,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    input  logic [CPU_W-1:0]  eoi_cpu,
    output logic              pop,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] run_prio,
    output logic              nest_full,
    output nest_state_e       state
);

    localparam int CNT_W = $clog2(NEST + 1);
    localparam int IDX_W = (NEST > 1) ? $clog2(NEST) : 1;

    logic [NEST-1:0][ID_W-1:0]   slot_id;
    logic [NEST-1:0][CPU_W-1:0]  slot_cpu;
    logic [NEST-1:0][PRIO_W-1:0] slot_prio;

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_idx;
    logic [CPU_W-1:0] top_cpu;
    logic [PRIO_W-1:0] top_prio;
    nest_state_e      state_q;
    nest_state_e      state_d;

    generate
        for (genvar k = 0; k < NEST; k++) begin : g_slot
            logic [ID_W-1:0]   sid_q;
            logic [CPU_W-1:0]  scpu_q;
            logic [PRIO_W-1:0] sprio_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sid_q   <= '0;
                    scpu_q  <= '0;
                    sprio_q <= '1;
                end else if (push && cnt_q == CNT_W'(k)) begin
                    sid_q   <= push_id;
                    scpu_q  <= push_cpu;
                    sprio_q <= push_prio;
                end
            end
            assign slot_id[k]   = sid_q;
            assign slot_cpu[k]  = scpu_q;
            assign slot_prio[k] = sprio_q;
        end
    endgenerate

    assign top_idx  = IDX_W'(cnt_q - CNT_W'(1));
    assign top_id   = slot_id[top_idx];
    assign top_cpu  = slot_cpu[top_idx];
    assign top_prio = slot_prio[top_idx];
    assign pop      = eoi_req && (cnt_q != '0) && (eoi_id == top_id) && (eoi_cpu == top_cpu);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push) begin
                    state_d = (NEST == 1) ? ST_SATURATED : ST_SERVING;
                end
            end
            ST_SERVING: begin
                if (push && cnt_q == CNT_W'(NEST - 1)) begin
                    state_d = ST_SATURATED;
                end else if (pop && cnt_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SATURATED: begin
                if (pop) begin
                    state_d = (NEST == 1) ? ST_IDLE : ST_SERVING;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and depth count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (push) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (pop) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        nest_full = 1'b0;
        run_prio  = '1;
        unique case (state_q)
            ST_IDLE:      run_prio = '1;
            ST_SERVING:   run_prio = top_prio;
            ST_SATURATED: begin
                run_prio  = top_prio;
                nest_full = 1'b1;
            end
            default:      run_prio = '1;
        endcase
    end

    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NEST));

    assert_no_push_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state_q != ST_SATURATED));

    assert_running_follows_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (run_prio == $past(push_prio)));

    assert_idle_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> (run_prio == '1));

    assert_mismatch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !push && ((eoi_id != top_id) || (eoi_cpu != top_cpu))) |=>
            (run_prio == $past(run_prio)));

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpuif_pkg::*;
#(
    parameter int NEST      = 4,
    parameter int ID_W      = 10,
    parameter int CPU_W     = 3,
    parameter int PRIO_W    = 8,
    parameter int PRIO_BITS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_valid_i,
    input  logic [ID_W-1:0]   pend_id_i,
    input  logic [CPU_W-1:0]  pend_cpu_i,
    input  logic [PRIO_W-1:0] pend_prio_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              ack_vld_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic              eoi_vld_o,
    output logic [ID_W-1:0]   eoi_id_o
);

    localparam int LOW_W = PRIO_W - PRIO_BITS;
    localparam logic [ID_W-1:0] SPURIOUS = '1;

    logic              sig_en;
    logic [PRIO_W-1:0] pmask;
    logic              ack_rd;
    logic              eoi_wr;
    logic              qualify;
    logic              nest_full;
    logic              pop;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] run_prio;
    logic [PRIO_W-1:0] push_prio;
    logic [DATA_W-1:0] ack_word;
    logic [DATA_W-1:0] hipend_word;
    nest_state_e       nest_state;

    always_comb begin
        push_prio = pend_prio_i;
        push_prio[LOW_W-1:0] = '0;
        ack_word = '0;
        hipend_word = '0;
        if (qualify) begin
            ack_word[ID_W+CPU_W-1:0] = {pend_cpu_i, pend_id_i};
        end else begin
            ack_word[ID_W-1:0] = SPURIOUS;
        end
        if (pend_valid_i) begin
            hipend_word[ID_W+CPU_W-1:0] = {pend_cpu_i, pend_id_i};
        end else begin
            hipend_word[ID_W-1:0] = SPURIOUS;
        end
    end

    cpuif_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .PRIO_BITS(PRIO_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i), .bus_wdata(bus_wdata_i),
        .ack_word(ack_word), .hipend_word(hipend_word), .run_prio(run_prio),
        .sig_en(sig_en), .pmask(pmask), .ack_rd(ack_rd), .eoi_wr(eoi_wr),
        .bus_rdata(bus_rdata_o)
    );

    cpuif_select #(
        .PRIO_W(PRIO_W), .PRIO_BITS(PRIO_BITS)
    ) u_select (
        .sig_en(sig_en), .pend_valid(pend_valid_i), .pend_prio(pend_prio_i),
        .pmask(pmask), .run_prio(run_prio), .nest_full(nest_full), .ack_rd(ack_rd),
        .qualify(qualify), .irq_line(irq_o)
    );

    cpuif_nest #(
        .NEST(NEST), .ID_W(ID_W), .CPU_W(CPU_W), .PRIO_W(PRIO_W)
    ) u_nest (
        .clk(clk), .rst_n(rst_n),
        .push(ack_rd && qualify), .push_id(pend_id_i), .push_cpu(pend_cpu_i), .push_prio(push_prio),
        .eoi_req(eoi_wr), .eoi_id(bus_wdata_i[ID_W-1:0]), .eoi_cpu(bus_wdata_i[ID_W+CPU_W-1:ID_W]),
        .pop(pop), .top_id(top_id), .run_prio(run_prio), .nest_full(nest_full), .state(nest_state)
    );

    assign ack_vld_o = ack_rd && qualify;
    assign ack_id_o  = pend_id_i;
    assign eoi_vld_o = pop;
    assign eoi_id_o  = top_id;

    assert_irq_under_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_prio_i[PRIO_W-1 -: PRIO_BITS] < pmask[PRIO_W-1 -: PRIO_BITS]));

    assert_irq_off_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(OFS_ACK)) |-> !irq_o);

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_en |-> (!irq_o && !ack_vld_o));

    assert_spurious_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !ack_vld_o && !eoi_wr) |=> (run_prio == $past(run_prio)));

    assert_claim_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |=> (nest_state != ST_IDLE));

endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;

    localparam int NEST = 3;
    localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_BPT = 8'h08, A_ACK = 8'h0C,
                           A_EOI = 8'h10, A_RUN = 8'h14, A_HIP = 8'h18;
    localparam logic [31:0] SPUR = 32'd1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_valid = 1'b0;
    logic [9:0]  p_id = '0;
    logic [2:0]  p_cpu = '0;
    logic [7:0]  p_prio = 8'hFF;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, ackv, eoiv;
    logic [9:0]  ack_id, eoi_id;

    int checks = 0;
    int errors = 0;

    // bench model
    logic       en_m = 1'b0;
    logic [7:0] mask_m = 8'h00;
    int         cnt_m = 0;
    logic [9:0] st_id [NEST];
    logic [2:0] st_cpu [NEST];
    logic [7:0] st_prio [NEST];

    always #10 clk = ~clk;

    cpu_irq_iface #(.NEST(NEST)) i_cpu_irq_iface (
        .clk(clk), .rst_n(rst_n),
        .pend_valid_i(p_valid), .pend_id_i(p_id), .pend_cpu_i(p_cpu), .pend_prio_i(p_prio),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .ack_vld_o(ackv), .ack_id_o(ack_id),
        .eoi_vld_o(eoiv), .eoi_id_o(eoi_id)
    );

    function automatic logic [7:0] run_m();
        return (cnt_m == 0) ? 8'hFF : st_prio[cnt_m-1];
    endfunction

    function automatic logic qual_m();
        logic [7:0] r;
        r = run_m();
        return en_m && p_valid && (cnt_m < NEST) &&
               (p_prio[7:4] < mask_m[7:4]) && (p_prio[7:4] < r[7:4]);
    endfunction

    function automatic logic [31:0] top_word_m();
        return (cnt_m == 0) ? 32'h0 : {19'd0, st_cpu[cnt_m-1], st_id[cnt_m-1]};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d, output logic irq_s, output logic ackv_s);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #5;
        d = rdata; irq_s = irq; ackv_s = ackv;
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] v, output logic eoiv_s);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        #5;
        eoiv_s = eoiv;
        @(posedge clk);
        #1 begin sel = 1'b0; wr = 1'b0; end
    endtask

    task automatic set_pend(input logic v, input logic [9:0] id, input logic [2:0] cpu, input logic [7:0] pr);
        @(negedge clk);
        p_valid = v; p_id = id; p_cpu = cpu; p_prio = pr;
    endtask

    task automatic set_ctrl(input logic e);
        logic dummy;
        wr_reg(A_CTRL, {31'd0, e}, dummy);
        en_m = e;
    endtask

    task automatic set_mask(input logic [7:0] m);
        logic dummy;
        wr_reg(A_MASK, {24'd0, m}, dummy);
        mask_m = {m[7:4], 4'h0};
    endtask

    task automatic do_ack(input string req);
        logic [31:0] d, expd;
        logic irq_s, ackv_s, q;
        q = qual_m();
        expd = q ? {19'd0, p_cpu, p_id} : SPUR;
        rd_reg(A_ACK, d, irq_s, ackv_s);
        chk(d == expd, req, d, expd);
        chk(irq_s == 1'b0, "R10", {31'd0, irq_s}, 32'd0);
        chk(ackv_s == q, q ? "R4" : "R5", {31'd0, ackv_s}, {31'd0, q});
        if (q) begin
            st_id[cnt_m] = p_id; st_cpu[cnt_m] = p_cpu; st_prio[cnt_m] = {p_prio[7:4], 4'h0};
            cnt_m++;
        end
    endtask

    task automatic do_eoi(input logic [31:0] v);
        logic e, match;
        match = (cnt_m > 0) && (v[12:0] == top_word_m()[12:0]);
        wr_reg(A_EOI, v, e);
        chk(e == match, match ? "R7" : "R8", {31'd0, e}, {31'd0, match});
        if (match) cnt_m--;
    endtask

    task automatic chk_run(input string req);
        logic [31:0] d;
        logic i_s, a_s;
        rd_reg(A_RUN, d, i_s, a_s);
        chk(d == {24'd0, run_m()}, req, d, {24'd0, run_m()});
    endtask

    task automatic chk_irq(input string req);
        logic e;
        @(negedge clk);
        #5;
        e = qual_m();
        chk(irq == e, req, {31'd0, irq}, {31'd0, e});
    endtask

    task automatic chk_hip();
        logic [31:0] d, expd;
        logic i_s, a_s;
        expd = p_valid ? {19'd0, p_cpu, p_id} : SPUR;
        rd_reg(A_HIP, d, i_s, a_s);
        chk(d == expd, "R9", d, expd);
        chk(a_s == 1'b0, "R9", {31'd0, a_s}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic i_s, a_s, dm;
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(A_CTRL, d, i_s, a_s); chk(d == 0, "R1", d, 0);
        rd_reg(A_MASK, d, i_s, a_s); chk(d == 0, "R1", d, 0);
        chk_run("R1");
        chk(irq == 1'b0, "R1", {31'd0, irq}, 0);
        set_pend(1'b1, 10'd33, 3'd0, 8'h10);
        do_ack("R1");

        // R11 binary point
        rd_reg(A_BPT, d, i_s, a_s); chk(d == 3, "R11", d, 3);
        wr_reg(A_BPT, 32'h7, dm);
        rd_reg(A_BPT, d, i_s, a_s); chk(d == 3, "R11", d, 3);

        // R3 mask storage
        set_mask(8'h5A);
        rd_reg(A_MASK, d, i_s, a_s); chk(d == 32'h50, "R3", d, 32'h50);

        // R2 enable gating
        chk_irq("R2");
        do_ack("R2");
        set_ctrl(1'b1);
        chk_irq("R2");
        chk(irq == 1'b1, "R2", {31'd0, irq}, 1);

        // R3 nibble corners
        set_pend(1'b1, 10'd50, 3'd0, 8'h4F); chk_irq("R3");
        set_pend(1'b1, 10'd50, 3'd0, 8'h50); chk_irq("R3");
        set_pend(1'b1, 10'd50, 3'd0, 8'h5F); chk_irq("R3");
        do_ack("R5");

        // nesting to saturation
        set_mask(8'hF0);
        set_pend(1'b1, 10'd40, 3'd0, 8'h8C); do_ack("R4");
        chk_run("R6");
        chk_irq("R6");
        do_ack("R6");
        set_pend(1'b1, 10'd41, 3'd0, 8'h70); do_ack("R4");
        set_pend(1'b1, 10'd2, 3'd5, 8'h60); do_ack("R4");
        chk_run("R6");
        set_pend(1'b1, 10'd7, 3'd1, 8'h10);
        chk_irq("R10");
        do_ack("R10");
        chk_hip();
        chk_run("R9");
        do_eoi(32'd40);
        chk_run("R8");
        do_eoi({19'd0, 3'd1, 10'd2});
        chk_run("R8");
        do_eoi({19'd0, 3'd5, 10'd2});
        chk_run("R7");
        do_eoi(32'd41);
        do_eoi(32'd40);
        chk_run("R7");
        set_pend(1'b0, 10'd0, 3'd0, 8'h00);
        chk_hip();
        do_ack("R5");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int op;
            set_pend(($urandom % 5) != 0, 10'($urandom % 1020), 3'($urandom), 8'($urandom));
            op = $urandom % 8;
            case (op)
                0, 1: do_ack("R4");
                2:    do_eoi(top_word_m());
                3:    do_eoi({19'd0, 13'($urandom)});
                4:    chk_irq("R6");
                5:    chk_run("R6");
                6:    chk_hip();
                default: if (($urandom % 4) == 0) set_mask(8'($urandom)); else chk_irq("R3");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule